// File: doc/BRIEF.md
# Serial Control Register Port

This block lets a host load a bank of configuration registers over a few serial wires. It takes 16-bit control words, most significant bit first. The upper 7 bits select a register and the lower 9 bits are the new value. Every stored register drives a slice of one parallel output bus.

The `mode_2w` input selects one of two wire protocols.
- **Three-wire:** the host lowers a chip-select line and clocks the word in. When it raises chip-select again, the word is committed.
- **Two-wire:** the host opens a transfer with a start condition and then sends three bytes: a device byte, then the two halves of the word. The block acknowledges each byte it accepts by driving the shared data line low through an open-drain enable.

All serial lines are sampled by the system clock through two-stage synchronizers. The serial clocks must therefore run well below the system clock. Writing the reset register restores every stored register to its power-up value.

Top module: `ctl_serial_regs`

## Requirements
- R1: After `rst_n` is released, the stored registers hold these values, where register n occupies `regs_o[9n+8:9n]`:
  - registers 0 and 1: 9'h097, which is a 5-bit line-volume field 10111 in bits 4:0 plus a mute bit 1 in bit 7;
  - register 6: 9'h080, a power-off bit in bit 7;
  - register 7: 9'h002, a 2-bit format field 10 in bits 1:0;
  - registers 2, 3, 4, 5, 8 and 9: zero.
- R2: A control word is 16 bits sent MSB first: bits 15:9 are the register address and bits 8:0 are the data. Addresses 0 to 9 are stored registers. In three-wire mode, data is shifted on each rising `sclk` while `csb` is low, and the word is written when `csb` rises.
- R3: In three-wire mode, a `csb` rise that follows any number of clocked bits other than 16 (for example 15 or 17) changes no register.
- R4: In three-wire mode, `sda_oe` stays low at all times.
- R5: In two-wire mode, a transfer is a start condition followed by three bytes:
  - a device byte of {7'h1A, 1'b0};
  - a byte holding word bits 15:8;
  - a byte holding word bits 7:0.
  The block acknowledges each accepted byte by holding `sda_oe` high through the ninth clock. The write takes effect after the third byte.
- R6: In two-wire mode, a device byte with a different address, or with its last bit set to 1, is not acknowledged, and the rest of that transfer writes nothing.
- R7: In two-wire mode, a start condition (`sdin` falling while `sclk` is high) abandons any partial word and restarts the byte count. A stop condition (`sdin` rising while `sclk` is high) ends the transfer and releases `sda_oe`.
- R8: A completed write to address 15 (7'b0001111) returns every stored register to its R1 value, whatever data it carries.
- R9: A completed write to an address from 10 to 14 or from 16 to 127 changes no register. In two-wire mode such a write is still acknowledged on all three bytes.
- R10: A register changes only on a completed write. The new value appears on `regs_o` at the fourth rising `clk` edge after the pin edge that completes the write (the `csb` rise, or the falling `sclk` that ends the last data bit), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_2w | input | 1 | 1 selects the two-wire protocol, 0 selects three-wire |
| sclk | input | 1 | Serial bit clock from the host |
| sdin | input | 1 | Serial data line as seen on the wire |
| csb | input | 1 | Chip-select latch, used in three-wire mode only |
| sda_oe | output | 1 | When high, pulls the shared data line low to acknowledge |
| regs_o | output | 90 | Stored registers 0 to 9, register n at bits 9n+8:9n |

## Verification
Every pin change passes through two synchronizer flops and one edge register before it reaches the outputs:
- `sda_oe` reacts at the third rising `clk` edge after an `sclk` fall;
- `regs_o` changes at the fourth rising `clk` edge after the completing edge.

The bench drives the serial lines and samples the outputs on falling `clk` edges. It holds each serial phase for eight system cycles, so an acknowledge is sampled in the middle of the ninth clock's high phase. Register contents are compared only after a settling gap once the transfer has ended. One directed test counts falling edges after a `csb` rise and confirms that `regs_o` is unchanged at the third and updated at the fourth.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int AW      = 7;
  localparam int DW      = 9;
  localparam int WORD_W  = AW + DW;
  localparam int NSTORE  = 10;
  localparam int BUS_W   = NSTORE * DW;
  localparam logic [AW-1:0] RST_ADDR = 7'd15;

  // power-up value of one stored register
  function automatic logic [DW-1:0] reg_default(input int idx);
    logic [DW-1:0] v;
    v = '0;
    case (idx)
      0, 1: begin
        v[4:0] = 5'b10111;  // line volume
        v[7]   = 1'b1;      // mute
      end
      6: v[7]   = 1'b1;     // power off
      7: v[1:0] = 2'b10;    // format
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [BUS_W-1:0] default_bus();
    logic [BUS_W-1:0] b;
    for (int i = 0; i < NSTORE; i++) b[i*DW +: DW] = reg_default(i);
    return b;
  endfunction

  // decides whether a received two-wire byte is acknowledged
  function automatic logic byte_accept(input logic [1:0] idx, input logic [7:0] rx,
                                       input logic sel, input logic [AW-1:0] dev);
    if (idx == 2'd0) return rx == {dev, 1'b0};
    return sel && (idx != 2'd3);
  endfunction
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= din;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/ctl_3w.sv
module ctl_3w import ctl_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_rise,
  input  logic              csb_lvl,
  input  logic              csb_fall,
  input  logic              csb_rise,
  input  logic              sda_lvl,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_word
);
  localparam int CW = $clog2(WORD_W + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] SAT  = CW'(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      cnt     <= '0;
      wr_stb  <= 1'b0;
      wr_word <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (csb_fall) begin
        cnt <= '0;
      end else if (csb_rise) begin
        if (cnt == FULL) begin
          wr_stb  <= 1'b1;
          wr_word <= shreg;
        end
        cnt <= '0;
      end else if (sclk_rise && !csb_lvl) begin
        shreg <= {shreg[WORD_W-2:0], sda_lvl};
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctl_2w.sv
module ctl_2w import ctl_pkg::*; #(
  parameter logic [AW-1:0] DEV_ADDR = 7'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sclk_lvl,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              start_det,
  output logic              stop_det,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [WORD_W-1:0] wr_word
);
  logic       active, in_ack, selected;
  logic [3:0] bitcnt;
  logic [1:0] byte_idx;
  logic [7:0] shreg, hi_byte;
  logic       acc;

  assign start_det = en && sclk_lvl && sda_fall;
  assign stop_det  = en && sclk_lvl && sda_rise;
  assign acc       = byte_accept(byte_idx, shreg, selected, DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; in_ack <= 1'b0; selected <= 1'b0;
      bitcnt <= '0; byte_idx <= '0; shreg <= '0; hi_byte <= '0;
      sda_oe <= 1'b0; wr_stb <= 1'b0; wr_word <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!en) begin
        active <= 1'b0; in_ack <= 1'b0; selected <= 1'b0; sda_oe <= 1'b0;
      end else if (start_det) begin
        active <= 1'b1; in_ack <= 1'b0; selected <= 1'b0; sda_oe <= 1'b0;
        bitcnt <= '0; byte_idx <= '0;
      end else if (stop_det) begin
        active <= 1'b0; in_ack <= 1'b0; selected <= 1'b0; sda_oe <= 1'b0;
      end else if (active) begin
        if (sclk_rise && !in_ack && bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda_lvl};
          bitcnt <= bitcnt + 1'b1;
        end else if (sclk_fall && !in_ack && bitcnt == 4'd8) begin
          in_ack <= 1'b1;
          sda_oe <= acc;
          if (byte_idx == 2'd0) selected <= acc;
          if (byte_idx == 2'd1) hi_byte <= shreg;
          if (byte_idx == 2'd2 && acc) begin
            wr_stb  <= 1'b1;
            wr_word <= {hi_byte, shreg};
          end
        end else if (sclk_fall && in_ack) begin
          in_ack <= 1'b0;
          sda_oe <= 1'b0;
          bitcnt <= '0;
          if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile import ctl_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [BUS_W-1:0] regs_o
);
  logic rst_hit;
  assign rst_hit = wr_stb && (wr_addr == RST_ADDR);

  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  r <= reg_default(g);
      else if (rst_hit)                            r <= reg_default(g);
      else if (wr_stb && wr_addr == AW'(g))        r <= wr_data;
    end
    assign regs_o[g*DW +: DW] = r;
  end
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs import ctl_pkg::*; #(
  parameter logic [AW-1:0] DEV_ADDR = 7'h1A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_2w,
  input  logic             sclk,
  input  logic             sdin,
  input  logic             csb,
  output logic             sda_oe,
  output logic [BUS_W-1:0] regs_o
);
  logic [2:0] lvl, rise, fall;
  logic       stb3, stb2, wr_stb;
  logic [WORD_W-1:0] word3, word2, wr_word;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic       csb_rise, start_det, stop_det;

  ctl_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({csb, sdin, sclk}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign csb_rise = rise[2];

  ctl_3w u_3w (
    .clk(clk), .rst_n(rst_n), .en(!mode_2w),
    .sclk_rise(rise[0]), .csb_lvl(lvl[2]), .csb_fall(fall[2]), .csb_rise(csb_rise),
    .sda_lvl(lvl[1]), .wr_stb(stb3), .wr_word(word3)
  );

  ctl_2w #(.DEV_ADDR(DEV_ADDR)) u_2w (
    .clk(clk), .rst_n(rst_n), .en(mode_2w),
    .sclk_lvl(lvl[0]), .sclk_rise(rise[0]), .sclk_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_stb(stb2), .wr_word(word2)
  );

  assign wr_stb  = mode_2w ? stb2 : stb3;
  assign wr_word = mode_2w ? word2 : word3;
  assign wr_addr = wr_word[WORD_W-1 -: AW];
  assign wr_data = wr_word[DW-1:0];

  ctl_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/ctl_serial_regs_chk.sv
module ctl_serial_regs_chk import ctl_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_2w,
  input logic             sda_oe,
  input logic [BUS_W-1:0] regs_o,
  input logic             wr_stb,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             csb_rise,
  input logic             stop_det,
  input logic             start_det
);
  logic          last_stb;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_stb <= 1'b0; last_addr <= '0; last_data <= '0;
    end else begin
      last_stb <= wr_stb; last_addr <= wr_addr; last_data <= wr_data;
    end
  end

  // R4
  no_ack_3w_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_2w |-> !sda_oe);

  // R2
  latch_on_csb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !mode_2w) |-> $past(csb_rise));

  // R2
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_stb && last_addr < AW'(NSTORE)) |-> regs_o[last_addr*DW +: DW] == last_data);

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == RST_ADDR) |=> regs_o == default_bus());

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o));

  // R7
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || start_det) |=> !sda_oe);
endmodule

bind ctl_serial_regs ctl_serial_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_2w(mode_2w), .sda_oe(sda_oe), .regs_o(regs_o),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .csb_rise(csb_rise), .stop_det(stop_det), .start_det(start_det)
);

// File: tb/ctl_serial_regs_tb.sv
`timescale 1ns/1ps
module ctl_serial_regs_tb;
  localparam int H  = 8;
  localparam int NR = 10;
  localparam int BW = 90;
  localparam int NV = 10;
  // {mode, addr[6:0], data[8:0]}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 7'd0,   9'h1A5},
    {1'b0, 7'd7,   9'h03C},
    {1'b1, 7'd1,   9'h155},
    {1'b1, 7'd9,   9'h0FF},
    {1'b0, 7'd12,  9'h1FF},
    {1'b1, 7'd100, 9'h111},
    {1'b0, 7'd15,  9'h000},
    {1'b1, 7'd4,   9'h100},
    {1'b1, 7'd15,  9'h0AA},
    {1'b0, 7'd3,   9'h001}
  };

  logic clk = 0, rst_n = 0, mode_2w = 0;
  logic sclk = 1, m_sda = 1, csb = 1;
  logic sda_oe;
  logic [BW-1:0] regs_o;
  wire sdin_w = m_sda & ~sda_oe;

  int checks = 0, errors = 0, oe_in_3w = 0;
  logic [8:0] mdl [NR];

  always #2.5 clk = ~clk;

  ctl_serial_regs u_dut (
    .clk(clk), .rst_n(rst_n), .mode_2w(mode_2w), .sclk(sclk), .sdin(sdin_w),
    .csb(csb), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  always @(negedge clk) if (rst_n && !mode_2w && sda_oe) oe_in_3w++;

  function automatic logic [8:0] bdef(input int i);
    if (i < 2)  return 9'b0_1001_0111;
    if (i == 6) return 9'b1_0000_000 << 1 >> 1;
    if (i == 7) return 9'b0_0000_0010;
    return 9'd0;
  endfunction

  function automatic logic [BW-1:0] mdl_bus();
    logic [BW-1:0] b;
    for (int i = 0; i < NR; i++) b[i*9 +: 9] = mdl[i];
    return b;
  endfunction

  task automatic mdl_reset();
    for (int i = 0; i < NR; i++) mdl[i] = bdef(i);
  endtask

  task automatic mdl_write(input logic [6:0] a, input logic [8:0] d);
    if (a == 7'd15) mdl_reset();
    else if (a < 7'd10) mdl[a] = d;
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic w3_bits(input logic [15:0] w, input int nb);
    csb = 0; wt(H);
    for (int i = 0; i < nb; i++) begin
      sclk = 0; m_sda = (i < 16) ? w[15-i] : 1'b0; wt(H);
      sclk = 1; wt(H);
    end
  endtask

  task automatic w3(input logic [15:0] w, input int nb);
    w3_bits(w, nb);
    csb = 1; wt(H); m_sda = 1; wt(2*H);
  endtask

  task automatic i2_start();
    m_sda = 1; sclk = 1; wt(H); m_sda = 0; wt(H); sclk = 0; wt(H);
  endtask

  task automatic i2_stop();
    sclk = 0; m_sda = 0; wt(H); sclk = 1; wt(H); m_sda = 1; wt(2*H);
  endtask

  task automatic i2_byte(input logic [7:0] b, output logic ack);
    for (int i = 0; i < 8; i++) begin
      m_sda = b[7-i]; wt(H); sclk = 1; wt(H); sclk = 0; wt(H);
    end
    m_sda = 1; wt(H); sclk = 1; wt(H/2); ack = sda_oe; wt(H/2); sclk = 0; wt(H);
  endtask

  task automatic i2_write(input logic [7:0] devb, input logic [6:0] a, input logic [8:0] d,
                          output logic [2:0] acks);
    i2_start();
    i2_byte(devb, acks[2]);
    i2_byte({a, d[8]}, acks[1]);
    i2_byte(d[7:0], acks[0]);
    i2_stop();
  endtask

  task automatic set_mode(input logic m);
    mode_2w = m; sclk = 1; m_sda = 1; csb = 1; wt(2*H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    mdl_reset();
    wt(4); rst_n = 1; wt(4);
    // R1 reset values
    check("R1 reset defaults", regs_o, mdl_bus());

    // table walk: R2 R5 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic m; logic [6:0] a; logic [8:0] d;
      {m, a, d} = VEC[v];
      set_mode(m);
      if (m) begin
        i2_write({7'h1A, 1'b0}, a, d, acks);
        check(a > 9 && a != 15 ? "R9 acks on unimplemented" : "R5 acks", BW'(acks), BW'(3'b111));
      end else begin
        w3({a, d}, 16);
      end
      mdl_write(a, d);
      check(a == 15 ? "R8 reset register" : (a > 9 ? "R9 ignored address" : "R2 write"),
            regs_o, mdl_bus());
    end

    // R3 wrong bit counts
    set_mode(0);
    w3({7'd2, 9'h1EE}, 15);
    check("R3 fifteen bits discarded", regs_o, mdl_bus());
    w3({7'd2, 9'h1EE}, 17);
    check("R3 seventeen bits discarded", regs_o, mdl_bus());

    // R10 latency after csb rise
    w3_bits({7'd5, 9'h0C3}, 16);
    csb = 1;
    wt(3);
    check("R10 not before fourth edge", regs_o, mdl_bus());
    mdl_write(7'd5, 9'h0C3);
    wt(1);
    check("R10 at fourth edge", regs_o, mdl_bus());
    wt(H); m_sda = 1; wt(H);

    // R4 no acknowledge drive in three-wire mode
    check("R4 sda_oe quiet in 3-wire", BW'(oe_in_3w), BW'(0));

    // R6 wrong device address / read bit
    set_mode(1);
    i2_write({7'h1B, 1'b0}, 7'd2, 9'h077, acks);
    check("R6 wrong device no ack", BW'(acks), BW'(3'b000));
    check("R6 wrong device no write", regs_o, mdl_bus());
    i2_write({7'h1A, 1'b1}, 7'd2, 9'h077, acks);
    check("R6 read bit no ack", BW'(acks), BW'(3'b000));
    check("R6 read bit no write", regs_o, mdl_bus());

    // R7 repeated start abandons partial word
    i2_start();
    i2_byte({7'h1A, 1'b0}, acks[2]);
    i2_byte({7'd8, 1'b1}, acks[1]);
    sclk = 1; wt(H); m_sda = 1; wt(H);
    i2_start();
    i2_byte({7'h1A, 1'b0}, acks[2]);
    i2_byte({7'd8, 1'b0}, acks[1]);
    i2_byte(8'h5A, acks[0]);
    i2_stop();
    mdl_write(7'd8, 9'h05A);
    check("R7 restart then full write", regs_o, mdl_bus());
    // R7 stop mid-word writes nothing, releases line
    i2_start();
    i2_byte({7'h1A, 1'b0}, acks[2]);
    i2_byte({7'd8, 1'b1}, acks[1]);
    i2_stop();
    check("R7 stop abandons word", regs_o, mdl_bus());
    check("R7 sda_oe released", BW'(sda_oe), BW'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule